// File: doc/BRIEF.md
# Low-Energy Operand Fetch Register File

This block is the integer register file of a single-issue pipeline, wrapped in control logic that keeps the storage array and the operand latches idle whenever their work would not change the result. It holds 32 registers of 32 bits. Register 0 has no storage and always reads as zero. It has two read ports, called rs and rt, and one write port. A third latch, the store-data latch, captures the rt operand for stores.

Each cycle the decode stage presents one instruction through `iss_vld`. For each operand it gives the register index, a need flag, and a bypass-hit flag with the forwarded value. The block works out each array read strobe combinationally in the same cycle, so the strobe is ready before the read fires. The operand latches update at the following clock edge.

An array read is skipped for each of these reasons:
- the operand is unused;
- forwarding supplies the operand;
- the register is 0;
- the register is being written in the same cycle;
- the port's latch already holds an unmodified copy of the register.

In every case the delivered operand matches that of a conventional register file with full forwarding. Activity counters expose the saving.

The issue interface is a one-sided valid stream. There is no ready signal and the block never applies back-pressure: every cycle with `iss_vld` high is consumed at that clock edge. Writes are accepted whenever `wr_en` is high, independent of `iss_vld`.

Top module: `regfile_lowpower`

## Requirements
- R1: After reset `rs_q`, `rt_q`, `sd_q` and all counters are zero, every register reads as zero, and no latch holds a reusable copy.
- R2: For a needed operand, the value in `rs_q`/`rt_q` after the clock edge has this priority: the bypass value if the bypass hit is set; otherwise zero for register 0; otherwise `wr_data` if the same register is written in that cycle; otherwise the stored register value.
- R3: An operand is needed only when `iss_vld` is high and its need flag is set. For the rt port, the need flag is `rt_need` or `sd_need`. For an operand that is not needed, the port's read strobe stays low and its latch holds its value.
- R4: A bypass hit drives the port's read strobe low, and the latch takes `*_byp_data`.
- R5: A read of register 0 drives no read strobe and delivers zero. A write to register 0 drives `wr_arr_en` low and changes nothing.
- R6: When a needed, non-bypassed, nonzero register is written in the same cycle, the port's read strobe stays low and the written value is delivered.
- R7: A needed, non-bypassed, nonzero read of the same register that the port's latch last loaded from the array reuses that copy. In that case the read strobe stays low, the latch is not enabled, and its value is unchanged. This applies only while the copy is valid.
- R8: The reusable copy becomes invalid when its register is written, or when the latch is reloaded from bypass, zero or write forwarding.
- R9: When `iss_vld` and `sd_need` are high, `sd_q` takes the rt operand delivered in that cycle, including a reused one. Otherwise `sd_q` holds its value.
- R10: Each counter increases by exactly one in a cycle where its event occurs, and otherwise holds. The events are: port read strobe (`*_rd_cnt`), port latch enable (`*_lat_cnt`), needed operand without an array read (`*_skip_cnt`), `wr_arr_en` (`wr_cnt`), and store-data latch load (`sd_lat_cnt`).
- R11: `rs_rd_en`/`rt_rd_en` are combinational in the issue cycle. A strobe is high exactly when its operand is needed and none of R4 to R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | Instruction issued this cycle |
| rs_addr | input | 5 | rs register index |
| rs_need | input | 1 | Instruction uses rs |
| rs_byp | input | 1 | Forwarding supplies rs |
| rs_byp_data | input | 32 | Forwarded rs value |
| rt_addr | input | 5 | rt register index |
| rt_need | input | 1 | Instruction uses rt |
| rt_byp | input | 1 | Forwarding supplies rt |
| rt_byp_data | input | 32 | Forwarded rt value |
| sd_need | input | 1 | Instruction is a store (uses rt as store data) |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write value |
| rs_rd_en | output | 1 | rs array read strobe |
| rt_rd_en | output | 1 | rt array read strobe |
| wr_arr_en | output | 1 | Array write strobe |
| rs_q | output | 32 | rs operand latch |
| rt_q | output | 32 | rt operand latch |
| sd_q | output | 32 | Store-data latch |
| rs_rd_cnt | output | 16 | rs array reads |
| rs_lat_cnt | output | 16 | rs latch enables |
| rs_skip_cnt | output | 16 | rs needed reads served without the array |
| rt_rd_cnt | output | 16 | rt array reads |
| rt_lat_cnt | output | 16 | rt latch enables |
| rt_skip_cnt | output | 16 | rt needed reads served without the array |
| wr_cnt | output | 16 | Array writes |
| sd_lat_cnt | output | 16 | Store-data latch loads |

## Verification
The bound checker watches the relations that hold every cycle. No read strobe fires for an unused operand, a bypassed operand, register 0, or a register under write. No array write happens to register 0. An idle latch keeps its value. A bypassed operand or register 0 delivers the expected value. The read and write counters step correctly. Only the bench's scenarios can show the read-reuse behaviour and its invalidation, the equivalence of delivered data with a conventional register file over long mixed sequences, and the store-data capture of a reused rt value. These need a model of the register contents and of each port's history.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  // Where a port's operand comes from in the current cycle
  typedef enum logic [2:0] {
    SRC_HOLD,   // operand not needed: latch idle
    SRC_ARRAY,  // read from storage
    SRC_BYP,    // forwarded value
    SRC_ZERO,   // register 0
    SRC_FWD,    // same-cycle write value
    SRC_REUSE   // latch already holds this register
  } rfl_src_e;

  localparam int unsigned RFL_PORTS = 2;
endpackage

// File: rtl/rfl_event_cnt.sv
module rfl_event_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfl_store.sv
module rfl_store #(
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 32,
  parameter int unsigned NRD = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0]          rd_en,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  localparam int unsigned NREG = 1 << AW;

  // Register 0 is not stored
  logic [NREG-1:1][DW-1:0] cells;

  for (genvar r = 1; r < NREG; r++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cells[r] <= '0;
      else if (wr_en && (wr_addr == AW'(r)))      cells[r] <= wr_data;
    end
  end

  // A read port drives nothing unless its strobe fires
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      rd_data[p] = '0;
      if (rd_en[p]) begin
        for (int r = 1; r < NREG; r++) begin
          if (rd_addr[p] == AW'(r)) rd_data[p] = cells[r];
        end
      end
    end
  end
endmodule

// File: rtl/rfl_port.sv
module rfl_port
  import rfl_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          need,
  input  logic [AW-1:0] addr,
  input  logic          byp,
  input  logic [DW-1:0] byp_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] arr_data,
  output logic          rd_en,
  output logic [DW-1:0] q,
  output logic [DW-1:0] nxt,
  output logic [CW-1:0] rd_cnt,
  output logic [CW-1:0] lat_cnt,
  output logic [CW-1:0] skip_cnt
);
  rfl_src_e      src;
  logic          is_zero, is_fwd, is_hit, lat_en;
  logic [AW-1:0] tag;
  logic          tag_vld;
  logic [DW-1:0] d;

  always_comb begin
    is_zero = (addr == '0);
    is_fwd  = wr_en && (wr_addr == addr) && !is_zero;
    is_hit  = tag_vld && (tag == addr) && !is_zero && !byp && !is_fwd;
    if (!need)        src = SRC_HOLD;
    else if (byp)     src = SRC_BYP;
    else if (is_zero) src = SRC_ZERO;
    else if (is_fwd)  src = SRC_FWD;
    else if (is_hit)  src = SRC_REUSE;
    else              src = SRC_ARRAY;
    rd_en  = (src == SRC_ARRAY);
    lat_en = (src != SRC_HOLD) && (src != SRC_REUSE);
    unique case (src)
      SRC_BYP:   d = byp_data;
      SRC_FWD:   d = wr_data;
      SRC_ARRAY: d = arr_data;
      default:   d = '0;
    endcase
    nxt = lat_en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      tag     <= '0;
      tag_vld <= 1'b0;
    end else if (lat_en) begin
      q       <= d;
      tag     <= addr;
      tag_vld <= rd_en;
    end else if (wr_en && (wr_addr == tag)) begin
      tag_vld <= 1'b0;
    end
  end

  rfl_event_cnt #(.CW(CW)) u_rd   (.clk(clk), .rst_n(rst_n), .inc(rd_en),          .cnt(rd_cnt));
  rfl_event_cnt #(.CW(CW)) u_lat  (.clk(clk), .rst_n(rst_n), .inc(lat_en),         .cnt(lat_cnt));
  rfl_event_cnt #(.CW(CW)) u_skip (.clk(clk), .rst_n(rst_n), .inc(need && !rd_en), .cnt(skip_cnt));
endmodule

// File: rtl/regfile_lowpower.sv
module regfile_lowpower
  import rfl_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_vld,
  input  logic [AW-1:0] rs_addr,
  input  logic          rs_need,
  input  logic          rs_byp,
  input  logic [DW-1:0] rs_byp_data,
  input  logic [AW-1:0] rt_addr,
  input  logic          rt_need,
  input  logic          rt_byp,
  input  logic [DW-1:0] rt_byp_data,
  input  logic          sd_need,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          rs_rd_en,
  output logic          rt_rd_en,
  output logic          wr_arr_en,
  output logic [DW-1:0] rs_q,
  output logic [DW-1:0] rt_q,
  output logic [DW-1:0] sd_q,
  output logic [CW-1:0] rs_rd_cnt,
  output logic [CW-1:0] rs_lat_cnt,
  output logic [CW-1:0] rs_skip_cnt,
  output logic [CW-1:0] rt_rd_cnt,
  output logic [CW-1:0] rt_lat_cnt,
  output logic [CW-1:0] rt_skip_cnt,
  output logic [CW-1:0] wr_cnt,
  output logic [CW-1:0] sd_lat_cnt
);
  localparam int unsigned NP = RFL_PORTS;

  logic [NP-1:0]          p_need, p_byp, p_rd_en;
  logic [NP-1:0][AW-1:0]  p_addr;
  logic [NP-1:0][DW-1:0]  p_byp_data, p_arr, p_q, p_nxt;
  logic [NP-1:0][CW-1:0]  p_rd_cnt, p_lat_cnt, p_skip_cnt;
  logic                   sd_load;

  // index 0 = rs, index 1 = rt (rt also feeds the store-data latch)
  assign p_need     = {iss_vld && (rt_need || sd_need), iss_vld && rs_need};
  assign p_addr     = {rt_addr, rs_addr};
  assign p_byp      = {rt_byp, rs_byp};
  assign p_byp_data = {rt_byp_data, rs_byp_data};
  assign wr_arr_en  = wr_en && (wr_addr != '0);

  rfl_store #(.AW(AW), .DW(DW), .NRD(NP)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_arr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(p_rd_en), .rd_addr(p_addr), .rd_data(p_arr)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    rfl_port #(.AW(AW), .DW(DW), .CW(CW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .need(p_need[p]), .addr(p_addr[p]),
      .byp(p_byp[p]), .byp_data(p_byp_data[p]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .arr_data(p_arr[p]),
      .rd_en(p_rd_en[p]), .q(p_q[p]), .nxt(p_nxt[p]),
      .rd_cnt(p_rd_cnt[p]), .lat_cnt(p_lat_cnt[p]), .skip_cnt(p_skip_cnt[p])
    );
  end

  // Store-data latch: clocked only for stores
  assign sd_load = iss_vld && sd_need;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sd_q <= '0;
    else if (sd_load) sd_q <= p_nxt[1];
  end

  rfl_event_cnt #(.CW(CW)) u_wr_cnt (.clk(clk), .rst_n(rst_n), .inc(wr_arr_en), .cnt(wr_cnt));
  rfl_event_cnt #(.CW(CW)) u_sd_cnt (.clk(clk), .rst_n(rst_n), .inc(sd_load),   .cnt(sd_lat_cnt));

  assign rs_rd_en    = p_rd_en[0];
  assign rt_rd_en    = p_rd_en[1];
  assign rs_q        = p_q[0];
  assign rt_q        = p_q[1];
  assign rs_rd_cnt   = p_rd_cnt[0];
  assign rt_rd_cnt   = p_rd_cnt[1];
  assign rs_lat_cnt  = p_lat_cnt[0];
  assign rt_lat_cnt  = p_lat_cnt[1];
  assign rs_skip_cnt = p_skip_cnt[0];
  assign rt_skip_cnt = p_skip_cnt[1];
endmodule

// File: rtl/regfile_lowpower_chk.sv
module regfile_lowpower_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_vld,
  input logic [AW-1:0] rs_addr,
  input logic          rs_need,
  input logic          rs_byp,
  input logic [DW-1:0] rs_byp_data,
  input logic          rt_need,
  input logic          rt_byp,
  input logic          sd_need,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          rs_rd_en,
  input logic          rt_rd_en,
  input logic          wr_arr_en,
  input logic [DW-1:0] rs_q,
  input logic [CW-1:0] rs_rd_cnt,
  input logic [CW-1:0] wr_cnt
);
  AST_RS_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_vld && rs_need) |-> !rs_rd_en);                                  // R3
  AST_RT_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_vld && (rt_need || sd_need)) |-> !rt_rd_en);                     // R3
  AST_RS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_vld && rs_need) |=> $stable(rs_q));                              // R3
  AST_RS_BYP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rs_byp |-> !rs_rd_en);                                                 // R4
  AST_RT_BYP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rt_byp |-> !rt_rd_en);                                                 // R4
  AST_RS_BYP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && rs_need && rs_byp) |=> (rs_q == $past(rs_byp_data)));     // R4
  AST_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_addr == '0) |-> !rs_rd_en);                                        // R5
  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == '0)) |-> !wr_arr_en);                            // R5
  AST_ZERO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && rs_need && !rs_byp && (rs_addr == '0)) |=> (rs_q == '0));  // R5
  AST_FWD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == rs_addr)) |-> !rs_rd_en);                        // R6
  AST_RD_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rs_rd_en |=> (rs_rd_cnt == $past(rs_rd_cnt) + 1'b1));                  // R10
  AST_WR_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_arr_en |=> $stable(wr_cnt));                                       // R10
endmodule

bind regfile_lowpower regfile_lowpower_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld),
  .rs_addr(rs_addr), .rs_need(rs_need), .rs_byp(rs_byp), .rs_byp_data(rs_byp_data),
  .rt_need(rt_need), .rt_byp(rt_byp), .sd_need(sd_need),
  .wr_en(wr_en), .wr_addr(wr_addr),
  .rs_rd_en(rs_rd_en), .rt_rd_en(rt_rd_en), .wr_arr_en(wr_arr_en),
  .rs_q(rs_q), .rs_rd_cnt(rs_rd_cnt), .wr_cnt(wr_cnt)
);

// File: tb/regfile_lowpower_tb_top.sv
module regfile_lowpower_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        iss_vld = 0, rs_need = 0, rs_byp = 0, rt_need = 0, rt_byp = 0, sd_need = 0, wr_en = 0;
  logic [4:0]  rs_addr = 0, rt_addr = 0, wr_addr = 0;
  logic [31:0] rs_byp_data = 0, rt_byp_data = 0, wr_data = 0;
  logic        rs_rd_en, rt_rd_en, wr_arr_en;
  logic [31:0] rs_q, rt_q, sd_q;
  logic [15:0] rs_rd_cnt, rs_lat_cnt, rs_skip_cnt, rt_rd_cnt, rt_lat_cnt, rt_skip_cnt, wr_cnt, sd_lat_cnt;

  int checks = 0, errors = 0;

  // reference state
  logic [31:0] m_mem [32];
  logic [31:0] m_q   [2];
  logic [4:0]  m_tag [2];
  bit          m_tv  [2];
  int unsigned m_rd[2], m_lat[2], m_skip[2], m_wr, m_sdc;
  logic [31:0] m_sd;

  regfile_lowpower dut_i (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld),
    .rs_addr(rs_addr), .rs_need(rs_need), .rs_byp(rs_byp), .rs_byp_data(rs_byp_data),
    .rt_addr(rt_addr), .rt_need(rt_need), .rt_byp(rt_byp), .rt_byp_data(rt_byp_data),
    .sd_need(sd_need), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rs_rd_en(rs_rd_en), .rt_rd_en(rt_rd_en), .wr_arr_en(wr_arr_en),
    .rs_q(rs_q), .rt_q(rt_q), .sd_q(sd_q),
    .rs_rd_cnt(rs_rd_cnt), .rs_lat_cnt(rs_lat_cnt), .rs_skip_cnt(rs_skip_cnt),
    .rt_rd_cnt(rt_rd_cnt), .rt_lat_cnt(rt_lat_cnt), .rt_skip_cnt(rt_skip_cnt),
    .wr_cnt(wr_cnt), .sd_lat_cnt(sd_lat_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog run hung actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // One issue cycle: drive after a falling edge, check strobes, clock, check latches
  task automatic step(input bit v,
                      input logic [4:0] a0, input bit n0, input bit b0, input logic [31:0] d0,
                      input logic [4:0] a1, input bit n1, input bit b1, input logic [31:0] d1,
                      input bit sdn, input bit we, input logic [4:0] wa, input logic [31:0] wd);
    logic [4:0]  a[2];
    bit          nd[2], bp[2], zero, fwd, hit, rd;
    logic [31:0] bd[2], dv, nxt[2];
    string       why[2];
    iss_vld = v; rs_addr = a0; rs_need = n0; rs_byp = b0; rs_byp_data = d0;
    rt_addr = a1; rt_need = n1; rt_byp = b1; rt_byp_data = d1;
    sd_need = sdn; wr_en = we; wr_addr = wa; wr_data = wd;
    a[0] = a0; a[1] = a1; bp[0] = b0; bp[1] = b1; bd[0] = d0; bd[1] = d1;
    nd[0] = v && n0; nd[1] = v && (n1 || sdn);
    #1;
    for (int p = 0; p < 2; p++) begin
      zero = (a[p] == 0);
      fwd  = we && (wa == a[p]) && !zero;
      hit  = nd[p] && m_tv[p] && (m_tag[p] == a[p]) && !bp[p] && !zero && !fwd;
      rd   = nd[p] && !bp[p] && !zero && !fwd && !hit;
      if (!nd[p])     why[p] = "R3";
      else if (bp[p]) why[p] = "R4";
      else if (zero)  why[p] = "R5";
      else if (fwd)   why[p] = "R6";
      else if (hit)   why[p] = "R7";
      else if (m_tag[p] == a[p]) why[p] = "R8";
      else            why[p] = "R2";
      chk(why[p], p == 0 ? "R11 rs_rd_en" : "R11 rt_rd_en",
          32'(p == 0 ? rs_rd_en : rt_rd_en), 32'(rd));
      dv = bp[p] ? bd[p] : zero ? 32'h0 : fwd ? wd : m_mem[a[p]];
      nxt[p] = (nd[p] && !hit) ? dv : m_q[p];
      if (rd) m_rd[p]++;
      if (nd[p] && !rd) m_skip[p]++;
      if (nd[p] && !hit) begin
        m_q[p] = dv; m_tag[p] = a[p]; m_tv[p] = rd; m_lat[p]++;
      end else if (we && wa == m_tag[p]) begin
        m_tv[p] = 0;
      end
    end
    chk("R5", "wr_arr_en", 32'(wr_arr_en), 32'(we && wa != 0));
    if (v && sdn) begin m_sd = nxt[1]; m_sdc++; end
    if (we && wa != 0) begin m_mem[wa] = wd; m_wr++; end
    @(posedge clk); @(negedge clk);
    chk(why[0], "rs_q", rs_q, m_q[0]);
    chk(why[1], "rt_q", rt_q, m_q[1]);
    chk("R9", "sd_q", sd_q, m_sd);
    chk("R10", "rs_rd_cnt", 32'(rs_rd_cnt), 32'(16'(m_rd[0])));
    chk("R10", "rs_lat_cnt", 32'(rs_lat_cnt), 32'(16'(m_lat[0])));
    chk("R10", "rs_skip_cnt", 32'(rs_skip_cnt), 32'(16'(m_skip[0])));
    chk("R10", "rt_rd_cnt", 32'(rt_rd_cnt), 32'(16'(m_rd[1])));
    chk("R10", "rt_lat_cnt", 32'(rt_lat_cnt), 32'(16'(m_lat[1])));
    chk("R10", "rt_skip_cnt", 32'(rt_skip_cnt), 32'(16'(m_skip[1])));
    chk("R10", "wr_cnt", 32'(wr_cnt), 32'(16'(m_wr)));
    chk("R10", "sd_lat_cnt", 32'(sd_lat_cnt), 32'(16'(m_sdc)));
  endtask

  function automatic logic [4:0] pick_reg();
    return ($urandom % 2) ? 5'($urandom % 4) : 5'($urandom % 32);
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int r = 0; r < 32; r++) m_mem[r] = '0;
    for (int p = 0; p < 2; p++) begin
      m_q[p] = '0; m_tag[p] = '0; m_tv[p] = 0; m_rd[p] = 0; m_lat[p] = 0; m_skip[p] = 0;
    end
    m_wr = 0; m_sdc = 0; m_sd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rs_q", rs_q, 0);
    chk("R1", "rt_q", rt_q, 0);
    chk("R1", "sd_q", sd_q, 0);
    chk("R1", "rs_rd_cnt", 32'(rs_rd_cnt), 0);
    chk("R1", "wr_cnt", 32'(wr_cnt), 0);
    // write r5 with no issue: no reads (R3)
    step(0, 5, 1, 0, 0, 5, 1, 0, 0, 1, 1, 5, 32'hAAAA_0005);
    // first read of r5 comes from the array (R2)
    step(1, 5, 1, 0, 0, 6, 0, 0, 0, 0, 0, 0, 0);
    // repeated read reuses the latch (R7)
    step(1, 5, 1, 0, 0, 6, 0, 0, 0, 0, 0, 0, 0);
    // write r5 between reads, then read again: copy invalid (R8)
    step(1, 5, 0, 0, 0, 6, 0, 0, 0, 0, 1, 5, 32'hBBBB_0005);
    step(1, 5, 1, 0, 0, 6, 0, 0, 0, 0, 0, 0, 0);
    // register 0 read and write (R5)
    step(1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 0, 32'hDEAD_BEEF);
    // bypass hit (R4)
    step(1, 5, 1, 1, 32'hCCCC_1234, 7, 1, 1, 32'h7777_0000, 0, 0, 0, 0);
    // same-cycle write forwarding (R6)
    step(1, 9, 1, 0, 0, 9, 1, 0, 0, 0, 1, 9, 32'h0D0D_0009);
    // store: rt reused then captured into sd (R9, R7)
    step(1, 1, 0, 0, 0, 5, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 5, 0, 0, 0, 1, 0, 0, 0);
    // constrained random mix
    for (int i = 0; i < N_RAND; i++) begin
      step(($urandom % 8) != 0,
           pick_reg(), ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom,
           pick_reg(), ($urandom % 2) == 0, ($urandom % 3) == 0, $urandom,
           ($urandom % 5) == 0, ($urandom % 2) == 0, pick_reg(), $urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule